// File: doc/BRIEF.md
# HDLC Bit-Level Frame Receiver

This block sits behind a serial line interface. It takes a recovered bit stream and a one-cycle strobe for each received bit, and passes octets to a downstream byte buffer. While hunting for a frame it looks for the flag octet 0x7E. Between flags it removes the zero that the transmitter inserted after each run of five ones. It assembles octets least significant bit first and forwards them, including the two frame check octets, in the order they arrived.

The last octet of each frame carries an end marker and a status word. The status tells whether the frame check passed, whether the frame was aborted, whether it was rejected as too short or not octet aligned, whether it held an odd number of octets, and whether any octet was lost to a full downstream buffer. A line held at ones is reported in two ways: an abort pulse for an open frame, and a level that shows the line has gone idle.

Top module: `hdlc_rx`

## Requirements
- R1: A flag (0x7E) opens a frame and the next flag closes it; one flag may close a frame and open the next. A flag pair with no bits between them produces no output beat.
- R2: Inside a frame, a 0 that follows five consecutive 1s is removed and contributes no data bit, so payload octets 0x7E and 0xFF are delivered unchanged.
- R3: Seven consecutive 1s while a frame holds at least one bit end that frame with one end-marked beat whose aborted bit is 1 and fcs_ok 0, plus one pulse on abort_pulse. Seven 1s after a flag with no frame content give no beat and no pulse.
- R4: line_idle is 1 once fifteen or more consecutive 1s have been received and returns to 0 with the next received 0.
- R5: On the end beat of an aligned frame of at least three octets, out_fcs_ok is 1 exactly when the CRC-16 (polynomial x^16+x^12+x^5+1, preset all ones, sent inverted, low octet first) over the whole frame leaves the residue of a correct frame.
- R6: out_odd is 1 on the end beat of an aligned frame whose total octet count, frame check octets included, is odd.
- R7: A frame whose bit count between flags is not a multiple of eight ends with an end beat that has out_invalid 1 and out_fcs_ok 0.
- R8: A frame of fewer than three octets ends with out_invalid 1 and out_fcs_ok 0.
- R9: When an octet is ready while out_ready is 0, it is dropped, overrun_pulse is 1 for one cycle, and the end beat of that frame has out_overrun 1.
- R10: Each octet is assembled with the first received bit as bit 0. Beats before the end beat have out_eof 0 and all status bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| rx_en | input | 1 | Strobe: rx_bit holds a new line bit this cycle |
| rx_bit | input | 1 | Serial line bit |
| out_ready | input | 1 | Downstream buffer has room for an octet |
| out_valid | output | 1 | Octet beat present this cycle |
| out_data | output | 8 | Received octet |
| out_eof | output | 1 | Beat is the last of its frame |
| out_fcs_ok | output | 1 | End beat: frame check passed |
| out_odd | output | 1 | End beat: odd octet count |
| out_invalid | output | 1 | End beat: frame misaligned or too short |
| out_aborted | output | 1 | End beat: frame ended by abort |
| out_overrun | output | 1 | End beat: an octet of the frame was dropped |
| abort_pulse | output | 1 | One-cycle pulse per aborted frame |
| overrun_pulse | output | 1 | One-cycle pulse per dropped octet |
| line_idle | output | 1 | Line has shown fifteen or more ones |

## Verification
Random payloads of 1 to 16 octets, some with a corrupted check field, are compared octet by octet. These runs separate good check status from bad and odd totals from even ones. Directed payloads of 0xFF and 0x7E tell correct zero removal apart from zeros left in the stream or a false flag. A shared flag between two frames tests that a frame boundary does not lose or merge octets. Further cases force the distinct end statuses: abort after content, a run of ones after an empty flag, extra bits before the closing flag, a two-octet frame, and a stall of the downstream buffer.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam int OCTET = 8;
  localparam logic [7:0] FLAG_PAT = 8'h7E;
  localparam logic [15:0] CRC16_REV_POLY = 16'h8408;
  localparam logic [15:0] CRC16_GOOD_RES = 16'hF0B8;

  typedef struct packed {
    logic fcs_ok;
    logic odd;
    logic invalid;
    logic aborted;
    logic overrun;
  } frame_stat_t;

  // one bit of the reflected CRC-16 shift register
  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    return (c >> 1) ^ (fb ? CRC16_REV_POLY : 16'h0000);
  endfunction

  // a zero following five ones is a transparency bit
  function automatic logic is_stuffed(input logic [2:0] ones, input logic b);
    return (ones == 3'd5) && !b;
  endfunction
endpackage

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
#(
  parameter int ABORT_ONES = 7,
  parameter int IDLE_ONES  = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_en,
  input  logic rx_bit,
  output logic bit_v,
  output logic bit_d,
  output logic flag_ev,
  output logic abort_ev,
  output logic line_idle
);
  localparam int RUN_W = $clog2(IDLE_ONES + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(IDLE_ONES);
  localparam logic [RUN_W-1:0] RUN_ABT = RUN_W'(ABORT_ONES - 1);

  logic [OCTET-1:0] win, vmask, nwin;
  logic [RUN_W-1:0] run, run_nxt;
  logic [2:0] d_ones;
  logic frame_q;
  logic cand, drop, flag_hit, abort_hit;

  always_comb begin
    nwin = {rx_bit, win[OCTET-1:1]};
    flag_hit = rx_en && (nwin == FLAG_PAT);
    if (!rx_bit) run_nxt = '0;
    else if (run == RUN_MAX) run_nxt = run;
    else run_nxt = run + 1'b1;
    abort_hit = rx_en && rx_bit && (run == RUN_ABT);
    cand = rx_en && frame_q && vmask[0];
    drop = cand && is_stuffed(d_ones, win[0]);
  end

  assign bit_v     = cand && !drop && !abort_hit;
  assign bit_d     = win[0];
  assign flag_ev   = flag_hit;
  assign abort_ev  = abort_hit && frame_q;
  assign line_idle = (run == RUN_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win <= '0;
      vmask <= '0;
      run <= '0;
      d_ones <= '0;
      frame_q <= 1'b0;
    end else if (rx_en) begin
      win <= nwin;
      vmask <= flag_hit ? '0 : {1'b1, vmask[OCTET-1:1]};
      run <= run_nxt;
      if (flag_hit || abort_hit) d_ones <= '0;
      else if (cand) begin
        if (drop || !win[0]) d_ones <= '0;
        else if (d_ones != 3'd7) d_ones <= d_ones + 3'd1;
      end
      if (abort_hit) frame_q <= 1'b0;
      else if (flag_hit) frame_q <= 1'b1;
    end
  end

  assert_flag_abort_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_hit && abort_hit));
  assert_no_six_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cand |-> (d_ones <= 3'd5));
  assert_idle_needs_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_idle) |-> $past(rx_en && rx_bit));
endmodule

// File: rtl/hdlc_rx_fcs.sv
module hdlc_rx_fcs
  import hdlc_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bit_v,
  input  logic bit_d,
  output logic fcs_good
);
  logic [15:0] crc, crc_nxt;

  always_comb begin
    crc_nxt = bit_v ? crc16_step(crc, bit_d) : crc;
  end

  assign fcs_good = (crc_nxt == CRC16_GOOD_RES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc <= 16'hFFFF;
    else if (clr) crc <= 16'hFFFF;
    else crc <= crc_nxt;
  end
endmodule

// File: rtl/hdlc_rx_assembler.sv
module hdlc_rx_assembler
  import hdlc_rx_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int MIN_BYTES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_v,
  input  logic             bit_d,
  input  logic             flag_ev,
  input  logic             abort_ev,
  input  logic             fcs_good,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [OCTET-1:0] out_data,
  output logic             out_eof,
  output frame_stat_t      out_stat,
  output logic             ev_abort,
  output logic             ev_overrun
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(MIN_BYTES);

  logic [OCTET-1:0] sh, sh_n, hold, last_d;
  logic [2:0] bcnt, bcnt_n;
  logic [CNT_W-1:0] nbytes, nbytes_n;
  logic hold_v, ovr;
  logic byte_done, closing, nonempty, emit_mid, emit_end, aligned, runt;
  frame_stat_t stat_end;

  always_comb begin
    sh_n      = bit_v ? {bit_d, sh[OCTET-1:1]} : sh;
    bcnt_n    = bit_v ? bcnt + 3'd1 : bcnt;
    byte_done = bit_v && (bcnt == 3'd7);
    nbytes_n  = (byte_done && nbytes != CNT_MAX) ? nbytes + 1'b1 : nbytes;
    closing   = flag_ev || abort_ev;
    nonempty  = (nbytes_n != '0) || (bcnt_n != 3'd0);
    emit_mid  = !closing && bit_v && (bcnt == 3'd0) && hold_v;
    emit_end  = closing && nonempty;
    last_d    = byte_done ? sh_n : (hold_v ? hold : '0);
    aligned   = (bcnt_n == 3'd0);
    runt      = (nbytes_n < CNT_MIN);
    stat_end.aborted = abort_ev;
    stat_end.invalid = !abort_ev && (!aligned || runt);
    stat_end.odd     = aligned && nbytes_n[0];
    stat_end.fcs_ok  = !abort_ev && aligned && !runt && fcs_good;
    stat_end.overrun = ovr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0;
      bcnt <= '0;
      nbytes <= '0;
      hold <= '0;
      hold_v <= 1'b0;
      ovr <= 1'b0;
      out_valid <= 1'b0;
      out_data <= '0;
      out_eof <= 1'b0;
      out_stat <= '0;
      ev_abort <= 1'b0;
      ev_overrun <= 1'b0;
    end else begin
      if (closing) begin
        sh <= '0;
        bcnt <= '0;
        nbytes <= '0;
        hold_v <= 1'b0;
        ovr <= 1'b0;
      end else begin
        sh <= sh_n;
        bcnt <= bcnt_n;
        nbytes <= nbytes_n;
        if (byte_done) begin
          hold <= sh_n;
          hold_v <= 1'b1;
        end else if (emit_mid) begin
          hold_v <= 1'b0;
        end
        if (emit_mid && !out_ready) ovr <= 1'b1;
      end
      out_valid  <= (emit_mid || emit_end) && out_ready;
      out_data   <= emit_end ? last_d : hold;
      out_eof    <= emit_end && out_ready;
      out_stat   <= (emit_end && out_ready) ? stat_end : '0;
      ev_overrun <= (emit_mid || emit_end) && !out_ready;
      ev_abort   <= abort_ev && nonempty;
    end
  end

  assert_eof_has_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |-> out_valid);
  assert_fcs_ok_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_stat.fcs_ok |-> (out_eof && !out_stat.invalid && !out_stat.aborted));
  assert_overrun_when_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_overrun |-> $past(!out_ready));
  assert_mid_beat_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_eof) |-> (out_stat == '0));
endmodule

// File: rtl/hdlc_rx.sv
module hdlc_rx
  import hdlc_rx_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int ABORT_ONES = 7,
  parameter int IDLE_ONES  = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_en,
  input  logic       rx_bit,
  input  logic       out_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_eof,
  output logic       out_fcs_ok,
  output logic       out_odd,
  output logic       out_invalid,
  output logic       out_aborted,
  output logic       out_overrun,
  output logic       abort_pulse,
  output logic       overrun_pulse,
  output logic       line_idle
);
  localparam int FCS_W     = 16;
  localparam int MIN_BYTES = FCS_W / OCTET + 1;

  logic bit_v, bit_d, flag_ev, abort_ev, fcs_good;
  frame_stat_t stat;

  hdlc_rx_deframer #(.ABORT_ONES(ABORT_ONES), .IDLE_ONES(IDLE_ONES)) u_deframer (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_bit(rx_bit),
    .bit_v(bit_v), .bit_d(bit_d), .flag_ev(flag_ev), .abort_ev(abort_ev),
    .line_idle(line_idle)
  );

  hdlc_rx_fcs u_fcs (
    .clk(clk), .rst_n(rst_n), .clr(flag_ev || abort_ev),
    .bit_v(bit_v), .bit_d(bit_d), .fcs_good(fcs_good)
  );

  hdlc_rx_assembler #(.CNT_W(CNT_W), .MIN_BYTES(MIN_BYTES)) u_asm (
    .clk(clk), .rst_n(rst_n), .bit_v(bit_v), .bit_d(bit_d),
    .flag_ev(flag_ev), .abort_ev(abort_ev), .fcs_good(fcs_good),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .out_eof(out_eof), .out_stat(stat), .ev_abort(abort_pulse),
    .ev_overrun(overrun_pulse)
  );

  assign out_fcs_ok  = stat.fcs_ok;
  assign out_odd     = stat.odd;
  assign out_invalid = stat.invalid;
  assign out_aborted = stat.aborted;
  assign out_overrun = stat.overrun;
endmodule

// File: tb/tb_hdlc_rx.sv
`timescale 1ns/1ps
module tb_hdlc_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b0, rx_bit = 1'b1, out_ready = 1'b1;
  logic out_valid, out_eof, out_fcs_ok, out_odd, out_invalid, out_aborted, out_overrun;
  logic abort_pulse, overrun_pulse, line_idle;
  logic [7:0] out_data;

  always #2.5 clk = ~clk;

  hdlc_rx dut (.*);

  int tests = 0, fails = 0;
  int ones = 0;
  logic [7:0] tx [0:63];
  int tx_n;
  logic [7:0] rd [0:63];
  logic [4:0] rs [0:63];
  logic re [0:63];
  int rn = 0, ab_cnt = 0, ov_cnt = 0;

  always @(negedge clk) if (rst_n) begin
    if (out_valid && rn < 64) begin
      rd[rn] = out_data; re[rn] = out_eof;
      rs[rn] = {out_fcs_ok, out_odd, out_invalid, out_aborted, out_overrun};
      rn++;
    end
    if (abort_pulse) ab_cnt++;
    if (overrun_pulse) ov_cnt++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic line_bit(input logic b);
    @(negedge clk); rx_en = 1'b1; rx_bit = b;
    @(negedge clk); rx_en = 1'b0;
  endtask

  task automatic data_bit(input logic b);
    line_bit(b);
    if (b) begin
      ones++;
      if (ones == 5) begin line_bit(1'b0); ones = 0; end
    end else ones = 0;
  endtask

  task automatic send_flag();
    line_bit(0);
    for (int i = 0; i < 6; i++) line_bit(1);
    line_bit(0);
    ones = 0;
  endtask

  task automatic send_octet(input logic [7:0] v);
    for (int i = 0; i < 8; i++) data_bit(v[i]);
  endtask

  // MSB-first CRC over bit-reversed octets, reversed at the end
  function automatic logic [15:0] bench_fcs(input int n);
    logic [15:0] c = 16'hFFFF, r;
    for (int k = 0; k < n; k++)
      for (int i = 0; i < 8; i++) begin
        logic fb;
        fb = c[15] ^ tx[k][i];
        c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
      end
    for (int i = 0; i < 16; i++) r[i] = c[15-i];
    return ~r;
  endfunction

  task automatic append_fcs(input bit corrupt);
    logic [15:0] f;
    f = bench_fcs(tx_n);
    if (corrupt) f = f ^ 16'h0010;
    tx[tx_n] = f[7:0]; tx[tx_n+1] = f[15:8];
    tx_n += 2;
  endtask

  task automatic send_body();
    for (int k = 0; k < tx_n; k++) send_octet(tx[k]);
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  // compares the collected beats starting at base with tx[0..tx_n-1]
  task automatic check_frame(input int base, input string req, input bit good);
    bit same = 1;
    check(rn - base == tx_n, {req, " beat count"}, rn - base, tx_n);
    for (int k = 0; k < tx_n && base + k < rn; k++) begin
      if (rd[base+k] !== tx[k]) same = 0;
      if (re[base+k] !== (k == tx_n - 1)) same = 0;
      if (k < tx_n - 1 && rs[base+k] !== 5'd0) same = 0;
    end
    check(same, {req, " R10 octets/order"}, same, 1);
    if (rn > base) begin
      check(rs[rn-1] == {good, tx_n[0], 3'b000}, {req, " R5 R6 status"},
            rs[rn-1], {good, tx_n[0], 3'b000});
    end
  endtask

  initial begin
    #(200000 * 5);
    tests++; fails++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int s, base, n;
    bit bad;
    s = $urandom(32'd4242);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && !out_eof && !line_idle, "reset", {out_valid, out_eof, line_idle}, 0);

    // empty flag pair: R1
    send_flag(); send_flag(); send_flag(); settle();
    check(rn == 0, "R1 empty frame", rn, 0);

    // random frames: R5 R6 R10
    for (int f = 0; f < 20; f++) begin
      n = 1 + ($urandom % 16);
      bad = (($urandom % 4) == 0);
      tx_n = n;
      for (int k = 0; k < n; k++) tx[k] = 8'($urandom);
      append_fcs(bad);
      rn = 0;
      send_flag(); send_body(); send_flag(); settle();
      check_frame(0, bad ? "R5 bad fcs" : "R5 good fcs", !bad);
    end

    // transparency: R2
    tx_n = 6;
    tx[0] = 8'hFF; tx[1] = 8'h7E; tx[2] = 8'hFF; tx[3] = 8'h3F; tx[4] = 8'h7E; tx[5] = 8'hF8;
    append_fcs(0);
    rn = 0;
    send_flag(); send_body(); send_flag(); settle();
    check_frame(0, "R2 stuffed octets", 1);

    // shared flag: R1
    rn = 0;
    tx_n = 3; tx[0] = 8'h11; tx[1] = 8'h22; tx[2] = 8'h33; append_fcs(0);
    send_flag(); send_body(); send_flag();
    base = tx_n;
    tx_n = 4; tx[0] = 8'hA0; tx[1] = 8'h0B; tx[2] = 8'hC5; tx[3] = 8'h5C; append_fcs(0);
    send_body(); send_flag(); settle();
    check(rn == base + tx_n && re[base-1] == 1'b1, "R1 shared flag split", rn, base + tx_n);
    check_frame(base, "R1 second frame", 1);

    // abort after content: R3
    rn = 0; ab_cnt = 0;
    send_flag(); send_octet(8'h5A); send_octet(8'hC3); send_octet(8'h00);
    for (int i = 0; i < 7; i++) line_bit(1);
    line_bit(0); settle();
    check(rn == 3 && re[2] && rs[2] == 5'b00010, "R3 aborted end beat", {rn[7:0], rs[2]}, {8'd3, 5'b00010});
    check(rd[0] == 8'h5A && rd[1] == 8'hC3, "R3 octets before abort", {rd[0], rd[1]}, 16'h5AC3);
    check(ab_cnt == 1, "R3 abort pulse", ab_cnt, 1);

    // ones after an empty flag, idle level: R3 R4
    rn = 0; ab_cnt = 0;
    send_flag();
    for (int i = 0; i < 16; i++) line_bit(1);
    settle();
    check(line_idle == 1'b1, "R4 idle high", line_idle, 1);
    check(rn == 0 && ab_cnt == 0, "R3 no report on empty", rn + ab_cnt, 0);
    line_bit(0); settle();
    check(line_idle == 1'b0, "R4 idle low after zero", line_idle, 0);

    // misaligned: R7
    rn = 0;
    tx_n = 4; for (int k = 0; k < 4; k++) tx[k] = 8'($urandom); append_fcs(0);
    send_flag(); send_body();
    for (int i = 0; i < 4; i++) data_bit(0);
    send_flag(); settle();
    check(rn == tx_n + 1 && re[rn-1] && rs[rn-1][2] && !rs[rn-1][4], "R7 misaligned",
          {rn[7:0], rs[rn-1]}, {8'(tx_n + 1), 5'b00100});

    // runt: R8
    rn = 0;
    send_flag(); send_octet(8'h81); send_octet(8'h42); send_flag(); settle();
    check(rn == 2 && re[1] && rs[1] == 5'b00100 && rd[0] == 8'h81, "R8 runt",
          {rn[7:0], rs[1]}, {8'd2, 5'b00100});

    // overrun: R9
    rn = 0; ov_cnt = 0;
    tx_n = 10; for (int k = 0; k < 10; k++) tx[k] = 8'($urandom); append_fcs(0);
    send_flag();
    for (int k = 0; k < tx_n; k++) begin
      if (k == 3) out_ready = 1'b0;
      if (k == 6) out_ready = 1'b1;
      send_octet(tx[k]);
    end
    send_flag(); settle();
    check(ov_cnt > 0, "R9 overrun pulse", ov_cnt, 1);
    check(rn > 0 && rn < tx_n && re[rn-1] && rs[rn-1][0], "R9 end beat overrun",
          {rn[7:0], rs[rn-1]}, {8'(tx_n - ov_cnt), 5'b00001});

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule